// File: doc/BRIEF.md
# Masked Condition Flag Generator

This purely combinational block produces the next condition-flag word of an integer ALU. It takes the previous flag word, a per-operation update mask, the ALU result, the two operands that fed the ALU, and an operand size in bytes. Every flag bit chosen by the mask is rebuilt from the result and the operands at the chosen width. Every bit the mask leaves clear is copied from the previous word unchanged.

Eight flags are produced: carry, parity, auxiliary carry (out of bit 3), zero, sign, overflow, and two shadow flags. The shadow flags repeat the carry and zero conditions but are controlled by mask bits of their own. The shadow flags sit at positions chosen by parameters. Subtract-type operations are handled by the caller, which hands in the two's-complement negation of the second operand. The flags then describe the equivalent addition. Flag storage and the ALU datapath sit outside the block.

Top module: `cflag_gen`

## Requirements
- R1: Any bit of `new_flags` whose `upd_mask` bit is 0 equals the same bit of `old_flags`, including bits that carry no flag.
- R2: Carry (bit 0) is set, when masked, exactly when adding the two operands at the selected width carries out of the top bit of that width.
- R3: Auxiliary carry (bit 4) is set, when masked, exactly when adding the low four bits of the operands carries out of bit 3, whatever the width.
- R4: Zero (bit 6) is set, when masked, exactly when every result bit inside the selected width is 0.
- R5: Sign (bit 7) is set, when masked, to the top result bit of the selected width.
- R6: Parity (bit 2) is set, when masked, exactly when bits 7..0 of the result hold an even number of ones.
- R7: Overflow (bit 11) is set, when masked, exactly when both operands have the same top bit at the selected width and the result's top bit differs from it.
- R8: The shadow carry flag at bit `SHADOW_C_POS` (default 28) follows the carry condition of R2 under its own mask bit.
- R9: The shadow zero flag at bit `SHADOW_Z_POS` (default 29) follows the zero condition of R4 under its own mask bit.
- R10: `op_bytes` values 1, 2, 4 and 8 select 8, 16, 32 and 64-bit width. Every other code selects 64 bits. Operand and result bits above the selected width have no effect on any flag.
- R11: When the second operand is the two's-complement negation of a subtrahend, carry is set exactly when the subtraction does not borrow, and the other flags describe the difference.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| old_flags | input | FLAG_W (32) | Previous flag word |
| upd_mask | input | FLAG_W (32) | 1 = recompute this bit, 0 = keep it |
| result | input | 64 | ALU result |
| opnd_a | input | 64 | First ALU operand |
| opnd_b | input | 64 | Second ALU operand (negated by the caller for subtraction) |
| op_bytes | input | 4 | Operand size in bytes |
| new_flags | output | FLAG_W (32) | Next flag word |

## Verification
The sweep covers every `op_bytes` code against boundary operands: zero, one, all-ones, the lone sign bit, the largest positive value, and values that sit on the bit-3 carry. The bits above the selected width are filled with random data. A width decoder that is off by one, or that leaks upper lanes into the flags, shows up as wrong zero, sign or carry at 8, 16 and 32 bits. Unmapped size codes catch a decoder that falls to a narrow width. Random masks and old words catch merge logic that clears or copies the wrong bits. Directed subtract cases catch carry that is inverted into a borrow sense. Shadow flags that are wired to the main flags' mask bits disagree as soon as the two masks differ.

// File: rtl/cflag_pkg.sv
package cflag_pkg;

  // Fixed flag positions; a downstream condition decoder depends on them.
  localparam int CARRY_POS  = 0;
  localparam int PARITY_POS = 2;
  localparam int AUX_POS    = 4;
  localparam int ZERO_POS   = 6;
  localparam int SIGN_POS   = 7;
  localparam int OVF_POS    = 11;

  typedef struct packed {
    logic carry;
    logic aux;
    logic zero;
    logic sign;
    logic parity;
    logic ovf;
  } cond_t;

  // Carry out of one bit column, recovered from the two addends and the sum bit.
  function automatic logic col_carry(input logic a, input logic b, input logic s);
    return (a & b) | ((a ^ b) & ~s);
  endfunction

endpackage

// File: rtl/cflag_width_sel.sv
module cflag_width_sel #(
  parameter  int MAX_BYTES = 8,
  localparam int DW        = MAX_BYTES * 8,
  localparam int IDXW      = $clog2(DW)
) (
  input  logic [3:0]    op_bytes,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [DW-1:0] r_i,
  output logic          a_top_o,
  output logic          b_top_o,
  output logic          r_top_o,
  output logic [DW-1:0] r_live_o
);

  int unsigned nbytes;
  logic [IDXW-1:0] top_idx;
  logic [MAX_BYTES-1:0] lane_on;

  always_comb begin
    nbytes = MAX_BYTES;
    if ((op_bytes == 4'd1 || op_bytes == 4'd2 || op_bytes == 4'd4 || op_bytes == 4'd8) &&
        (32'(op_bytes) <= MAX_BYTES))
      nbytes = 32'(op_bytes);
    top_idx = IDXW'(nbytes * 8 - 1);
  end

  generate
    for (genvar l = 0; l < MAX_BYTES; l++) begin : g_lane
      assign lane_on[l] = (l < nbytes);
      assign r_live_o[l*8 +: 8] = lane_on[l] ? r_i[l*8 +: 8] : 8'h00;
    end
  endgenerate

  assign a_top_o = a_i[top_idx];
  assign b_top_o = b_i[top_idx];
  assign r_top_o = r_i[top_idx];

  always_comb begin
    AST_LANES_CONTIG: assert ((lane_on & (lane_on + 1'b1)) == '0)
      else $error("enabled lanes not contiguous from lane 0"); // R10
  end

endmodule

// File: rtl/cflag_cond.sv
module cflag_cond
  import cflag_pkg::*;
#(
  parameter  int MAX_BYTES = 8,
  localparam int DW        = MAX_BYTES * 8
) (
  input  logic          a_top_i,
  input  logic          b_top_i,
  input  logic          r_top_i,
  input  logic [3:0]    a_nib_i,
  input  logic [3:0]    b_nib_i,
  input  logic [3:0]    r_nib_i,
  input  logic [DW-1:0] r_live_i,
  output cond_t         cond_o
);

  logic a3, b3, r3;
  assign a3 = a_nib_i[3];
  assign b3 = b_nib_i[3];
  assign r3 = r_nib_i[3];

  always_comb begin
    cond_o.carry  = col_carry(a_top_i, b_top_i, r_top_i);
    cond_o.aux    = col_carry(a3, b3, r3);
    cond_o.zero   = (r_live_i == '0);
    cond_o.sign   = r_top_i;
    cond_o.parity = ~^r_live_i[7:0];
    cond_o.ovf    = (a_top_i == b_top_i) && (r_top_i != a_top_i);
  end

  always_comb begin
    AST_ZERO_NOT_NEG: assert (!(cond_o.zero && cond_o.sign))
      else $error("zero result reported negative"); // R5
    AST_ZERO_EVEN_PAR: assert (!cond_o.zero || cond_o.parity)
      else $error("zero result reported odd parity"); // R6
  end

endmodule

// File: rtl/cflag_merge.sv
module cflag_merge #(
  parameter int FLAG_W = 32
) (
  input  logic [FLAG_W-1:0] old_i,
  input  logic [FLAG_W-1:0] mask_i,
  input  logic [FLAG_W-1:0] cond_i,
  output logic [FLAG_W-1:0] new_o
);

  generate
    for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
      assign new_o[i] = mask_i[i] ? cond_i[i] : old_i[i];
    end
  endgenerate

  always_comb begin
    AST_KEEP_UNMASKED: assert (((new_o ^ old_i) & ~mask_i) == '0)
      else $error("unmasked flag changed"); // R1
    AST_MASKED_FROM_COND: assert (((new_o ^ cond_i) & mask_i) == '0)
      else $error("masked flag differs from its condition"); // R2
  end

endmodule

// File: rtl/cflag_gen.sv
module cflag_gen
  import cflag_pkg::*;
#(
  parameter  int FLAG_W       = 32,
  parameter  int MAX_BYTES    = 8,
  parameter  int SHADOW_C_POS = 28,
  parameter  int SHADOW_Z_POS = 29,
  localparam int DW           = MAX_BYTES * 8
) (
  input  logic [FLAG_W-1:0] old_flags,
  input  logic [FLAG_W-1:0] upd_mask,
  input  logic [DW-1:0]     result,
  input  logic [DW-1:0]     opnd_a,
  input  logic [DW-1:0]     opnd_b,
  input  logic [3:0]        op_bytes,
  output logic [FLAG_W-1:0] new_flags
);

  logic a_top, b_top, r_top;
  logic [DW-1:0] r_live;
  cond_t cond;
  logic [FLAG_W-1:0] cond_vec;

  cflag_width_sel #(.MAX_BYTES(MAX_BYTES)) u_width (
    .op_bytes (op_bytes),
    .a_i      (opnd_a),
    .b_i      (opnd_b),
    .r_i      (result),
    .a_top_o  (a_top),
    .b_top_o  (b_top),
    .r_top_o  (r_top),
    .r_live_o (r_live)
  );

  cflag_cond #(.MAX_BYTES(MAX_BYTES)) u_cond (
    .a_top_i  (a_top),
    .b_top_i  (b_top),
    .r_top_i  (r_top),
    .a_nib_i  (opnd_a[3:0]),
    .b_nib_i  (opnd_b[3:0]),
    .r_nib_i  (result[3:0]),
    .r_live_i (r_live),
    .cond_o   (cond)
  );

  always_comb begin
    cond_vec               = '0;
    cond_vec[CARRY_POS]    = cond.carry;
    cond_vec[PARITY_POS]   = cond.parity;
    cond_vec[AUX_POS]      = cond.aux;
    cond_vec[ZERO_POS]     = cond.zero;
    cond_vec[SIGN_POS]     = cond.sign;
    cond_vec[OVF_POS]      = cond.ovf;
    cond_vec[SHADOW_C_POS] = cond.carry;
    cond_vec[SHADOW_Z_POS] = cond.zero;
  end

  cflag_merge #(.FLAG_W(FLAG_W)) u_merge (
    .old_i  (old_flags),
    .mask_i (upd_mask),
    .cond_i (cond_vec),
    .new_o  (new_flags)
  );

  always_comb begin
    AST_SHADOW_CARRY: assert (!(upd_mask[SHADOW_C_POS] && upd_mask[CARRY_POS]) ||
                              (new_flags[SHADOW_C_POS] == new_flags[CARRY_POS]))
      else $error("shadow carry disagrees with carry"); // R8
    AST_SHADOW_ZERO: assert (!(upd_mask[SHADOW_Z_POS] && upd_mask[ZERO_POS]) ||
                             (new_flags[SHADOW_Z_POS] == new_flags[ZERO_POS]))
      else $error("shadow zero disagrees with zero"); // R9
  end

endmodule

// File: tb/cflag_gen_tb.sv
module cflag_gen_tb;

  localparam int FW = 32;
  localparam int SC = 28;
  localparam int SZ = 29;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [FW-1:0] old_flags, upd_mask, new_flags;
  logic [63:0] result, opnd_a, opnd_b;
  logic [3:0] op_bytes;

  int n_chk = 0;
  int n_bad = 0;
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  cflag_gen #(.FLAG_W(FW), .MAX_BYTES(8), .SHADOW_C_POS(SC), .SHADOW_Z_POS(SZ)) u_dut (
    .old_flags (old_flags),
    .upd_mask  (upd_mask),
    .result    (result),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .op_bytes  (op_bytes),
    .new_flags (new_flags)
  );

  function automatic logic [63:0] next_rng(input logic [63:0] x);
    logic [63:0] y = x;
    y = y ^ (y << 13);
    y = y ^ (y >> 7);
    y = y ^ (y << 17);
    return y;
  endfunction

  function automatic int width_of(input logic [3:0] sz);
    if (sz == 4'd1 || sz == 4'd2 || sz == 4'd4) return 32'(sz) * 8;
    return 64;
  endfunction

  function automatic logic [63:0] wmask(input int w);
    return (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
  endfunction

  // Arithmetic reference: flag word with all eight conditions at their positions.
  function automatic logic [FW-1:0] ref_cond(input logic [63:0] a, input logic [63:0] b,
                                             input logic [63:0] r, input logic [3:0] sz);
    int w = width_of(sz);
    logic [63:0] m = wmask(w);
    logic [64:0] sum = {1'b0, a & m} + {1'b0, b & m};
    logic [4:0] nsum = {1'b0, a[3:0]} + {1'b0, b[3:0]};
    logic sa = a[w-1];
    logic sb = b[w-1];
    logic sr = r[w-1];
    int ones = $countones(r[7:0]);
    logic [FW-1:0] v = '0;
    v[0]  = sum[w];
    v[2]  = (ones % 2 == 0);
    v[4]  = nsum[4];
    v[6]  = ((r & m) == 64'd0);
    v[7]  = sr;
    v[11] = (sa == sb) && (sr != sa);
    v[SC] = sum[w];
    v[SZ] = ((r & m) == 64'd0);
    return v;
  endfunction

  task automatic chk(input logic got, input logic exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b (size %0d a=%h b=%h r=%h)",
               tag, got, exp, op_bytes, opnd_a, opnd_b, result);
    end
  endtask

  task automatic apply_and_check(input logic [63:0] a, input logic [63:0] b,
                                 input logic [3:0] sz, input logic [FW-1:0] old,
                                 input logic [FW-1:0] msk);
    logic [FW-1:0] cv;
    logic [FW-1:0] keep;
    @(negedge clk);
    opnd_a = a;
    opnd_b = b;
    result = a + b;
    op_bytes = sz;
    old_flags = old;
    upd_mask = msk;
    #5;
    cv = ref_cond(a, b, a + b, sz);
    keep = (new_flags ^ old) & ~msk;
    n_chk++;
    if (keep != '0) begin
      n_bad++;
      $display("FAIL R1: got %h expected %h outside mask %h", new_flags, old, msk);
    end
    if (msk[0])  chk(new_flags[0],  cv[0],  (width_of(sz) == 64 && sz != 4'd8) ? "R10 carry" : "R2 carry");
    if (msk[4])  chk(new_flags[4],  cv[4],  "R3 aux");
    if (msk[6])  chk(new_flags[6],  cv[6],  (width_of(sz) == 64 && sz != 4'd8) ? "R10 zero" : "R4 zero");
    if (msk[7])  chk(new_flags[7],  cv[7],  "R5 sign");
    if (msk[2])  chk(new_flags[2],  cv[2],  "R6 parity");
    if (msk[11]) chk(new_flags[11], cv[11], "R7 overflow");
    if (msk[SC]) chk(new_flags[SC], cv[SC], "R8 shadow carry");
    if (msk[SZ]) chk(new_flags[SZ], cv[SZ], "R9 shadow zero");
  endtask

  function automatic logic [63:0] corner(input int k, input int w, input logic [63:0] rnd);
    logic [63:0] m = wmask(w);
    logic [63:0] base;
    case (k)
      0: base = 64'd0;
      1: base = 64'd1;
      2: base = m;
      3: base = 64'd1 << (w - 1);
      4: base = (64'd1 << (w - 1)) - 64'd1;
      5: base = 64'hF;
      6: base = 64'h8;
      default: base = rnd;
    endcase
    // Garbage above the selected width must not matter (R10).
    return (base & m) | (rnd & ~m);
  endfunction

  initial begin
    logic [FW-1:0] all_flags;
    all_flags = '0;
    all_flags[0] = 1'b1; all_flags[2] = 1'b1; all_flags[4] = 1'b1; all_flags[6] = 1'b1;
    all_flags[7] = 1'b1; all_flags[11] = 1'b1; all_flags[SC] = 1'b1; all_flags[SZ] = 1'b1;
    old_flags = '0; upd_mask = '0; result = '0; opnd_a = '0; opnd_b = '0; op_bytes = 4'd8;

    // Initial state: empty mask, zero inputs -> zero output (R1).
    #5;
    n_chk++;
    if (new_flags != '0) begin
      n_bad++;
      $display("FAIL R1: got %h expected %h at start", new_flags, {FW{1'b0}});
    end

    // Sweep all size codes and corner operands under four mask styles.
    for (int sz = 0; sz < 16; sz++) begin
      for (int ka = 0; ka < 8; ka++) begin
        for (int kb = 0; kb < 8; kb++) begin
          for (int mk = 0; mk < 4; mk++) begin
            logic [FW-1:0] msk;
            logic [FW-1:0] old;
            logic [63:0] ra, rb;
            int w;
            w = width_of(4'(sz));
            rng = next_rng(rng); ra = rng;
            rng = next_rng(rng); rb = rng;
            rng = next_rng(rng); old = rng[FW-1:0];
            case (mk)
              0: msk = '1;
              1: msk = '0;
              2: msk = rng[63:32];
              default: msk = all_flags ^ {FW{rng[5]}} & all_flags;
            endcase
            apply_and_check(corner(ka, w, ra), corner(kb, w, rb), 4'(sz), old, msk);
          end
        end
      end
    end

    // Shadow flags under their own mask bits only (R8, R9): 0xFF + 0x01 at byte width.
    apply_and_check(64'hFF, 64'h01, 4'd1, '0, (FW'(1) << SC) | (FW'(1) << SZ));
    chk(new_flags[0], 1'b0, "R8 carry untouched when only shadow masked");
    chk(new_flags[SC], 1'b1, "R8 shadow carry set");
    chk(new_flags[SZ], 1'b1, "R9 shadow zero set");

    // Subtraction via negated operand (R11): 5 - 3 at byte width, no borrow.
    apply_and_check(64'h05, 64'hFD, 4'd1, '0, all_flags);
    chk(new_flags[0], 1'b1, "R11 carry set when no borrow");
    chk(new_flags[7], 1'b0, "R11 sign of 2");
    // 3 - 5 at word width borrows: carry clear, sign set.
    apply_and_check(64'h03, 64'hFFFB, 4'd2, '0, all_flags);
    chk(new_flags[0], 1'b0, "R11 carry clear on borrow");
    chk(new_flags[7], 1'b1, "R11 sign of -2");
    // 0x80 - 1 at byte width: signed overflow.
    apply_and_check(64'h80, 64'hFF, 4'd1, '0, all_flags);
    chk(new_flags[11], 1'b1, "R11 overflow on 0x80-1");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule